// File: doc/BRIEF.md
# Serial Interrupt Request Slave Encoder

This block is the peripheral side of a serial interrupt wire. The wire is shared and open-drain, and it runs on the PCI clock. The block takes a vector of level interrupt requests and reports each one in its own three-clock slot of a repeating serial cycle. A cycle opens with a long low start pulse. Slot k then carries request k, with request 0 first. After the last slot, a short low stop pulse closes the cycle and chooses the idle behaviour for the next one.

The block never drives the wire directly. It presents an enable and a data value to an external pad, and it watches the resolved wire level. It tracks the start pulse, the slot position and the stop pulse. It takes a snapshot of the requests when the start pulse ends, so the values it reports stay fixed for the whole cycle. In quiet mode it can ask for a new cycle itself: when a request differs from the last reported value, it pulls the wire low for one clock, and the host then stretches that low into a full start pulse.

Top module: `sirqSlaveEncoder`

## Requirements
- R1: While reset is high, and on the first clock after it, `lineOe` and `lineData` are 0. The block leaves reset in continuous mode, so a change on `irqIn` while idle produces no drive.
- R2: When the wire has been low for at least 4 consecutive clocks and is then sampled high, the clock after that high sample is the sample phase of slot 0.
- R3: A low run of 1 to 3 clocks followed by high does not start a cycle. The outputs stay released afterwards.
- R4: Each slot lasts 3 clocks, in the order sample, recovery, turnaround. Slot k (counted from 0) begins 3k clocks after slot 0 begins. There are `NUM_IRQ` slots (16 by default).
- R5: For an active request (`irqIn` bit = 1), the outputs are `lineOe`=1, `lineData`=0 in the sample phase; `lineOe`=1, `lineData`=1 in the recovery phase; and `lineOe`=0, `lineData`=0 in the turnaround phase.
- R6: For an inactive request, `lineOe` and `lineData` are 0 in all three phases of its slot.
- R7: The requests are captured on the clock that detects the end of the start pulse. A change on `irqIn` during the slots does not change what is reported in that cycle.
- R8: After the last slot, the outputs stay released until the stop pulse has been seen. A low run of exactly 2 clocks then high selects quiet mode. A low run of 3 or more clocks then high selects continuous mode. Either one returns the block to idle.
- R9: In quiet mode, while idle, the block checks the current `irqIn` against the last captured snapshot. When they differ and the wire is high, the block drives exactly one clock of low (`lineOe`=1, `lineData`=0) in the clock after the difference is first sampled. It does not drive this low again until a new start pulse has been detected.
- R10: In continuous mode, the block never drives a start request.
- R11: A start request that the host extends to 4 or more low clocks in total starts a normal cycle, which reports the new requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high reset |
| irqIn | input | NUM_IRQ | Level interrupt requests, 1 = active |
| lineIn | input | 1 | Resolved level of the shared wire |
| lineOe | output | 1 | Pad drive enable |
| lineData | output | 1 | Value driven when `lineOe` is 1 (0 = pull low, 1 = drive high in recovery) |

## Verification
A slot counter that is off by one, or a phase counter that is out of step, moves every reported pulse. This is visible within three clocks of the end of the start pulse, because slot 0 is the first one checked. A snapshot taken at the wrong time shows up as wrong values in the slots after a mid-cycle change to the requests. Mode state that is wrong only shows up at the next idle period, either as a start request that is missing or as one that should not be there. The bench sweeps every single-bit request pattern plus several mixed ones, and compares each of the 48 slot clocks against the value it computes arithmetically.

// File: rtl/sirqPkg.sv
package sirqPkg;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2
  } phaseT;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FRAMES   = 2'd1,
    ST_STOPWAIT = 2'd2
  } stateT;

  typedef struct packed {
    logic takeSnap;
    logic fireReq;
    logic goQuiet;
    logic goCont;
  } ctrlStrobeT;

endpackage

// File: rtl/sirqDatapath.sv
module sirqDatapath
  import sirqPkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int CNT_W   = 4,
  localparam int FW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               lineIn,
  input  ctrlStrobeT         strobe,
  input  logic               inFrames,
  input  logic [FW-1:0]      frameIdx,
  input  phaseT              phase,
  output logic [CNT_W-1:0]   lowCnt,
  output logic               irqDiffers,
  output logic               quietMode,
  output logic               reqSent,
  output logic               lineOe,
  output logic               lineData
);

  logic [NUM_IRQ-1:0] irqSnap;
  logic               reqDrive;
  logic               slotActive;

  // Run length of consecutive low samples, saturating.
  always_ff @(posedge clk) begin
    if (rst || lineIn)          lowCnt <= '0;
    else if (lowCnt != '1)      lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                    irqSnap <= '0;
    else if (strobe.takeSnap)   irqSnap <= irqIn;
  end

  always_ff @(posedge clk) begin
    if (rst)                    quietMode <= 1'b0;
    else if (strobe.goQuiet)    quietMode <= 1'b1;
    else if (strobe.goCont)     quietMode <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                    reqSent <= 1'b0;
    else if (strobe.takeSnap)   reqSent <= 1'b0;
    else if (strobe.fireReq)    reqSent <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) reqDrive <= 1'b0;
    else     reqDrive <= strobe.fireReq;
  end

  assign irqDiffers = (irqIn != irqSnap);
  assign slotActive = irqSnap[frameIdx];

  always_comb begin
    if (inFrames) begin
      lineOe   = slotActive && (phase != PH_TURN);
      lineData = slotActive && (phase == PH_RECOVER);
    end else begin
      lineOe   = reqDrive;
      lineData = 1'b0;
    end
  end

  // R9: a start request lasts a single clock
  assert_req_single_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(reqDrive) |=> !reqDrive);

  // R10: drive outside the slots only happens in quiet mode
  assert_req_quiet_only_R10: assert property (@(posedge clk) disable iff (rst)
    (lineOe && !inFrames) |-> quietMode);

  // R7: snapshot frozen while slots run
  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (inFrames && $past(inFrames)) |-> $stable(irqSnap));

  // R5: the wire is only driven high while enabled
  assert_high_needs_oe_R5: assert property (@(posedge clk) disable iff (rst)
    lineData |-> lineOe);

endmodule

// File: rtl/sirqControl.sv
module sirqControl
  import sirqPkg::*;
#(
  parameter int NUM_IRQ    = 16,
  parameter int CNT_W      = 4,
  parameter int START_MIN  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  localparam int FW        = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lineIn,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic             irqDiffers,
  input  logic             quietMode,
  input  logic             reqSent,
  output ctrlStrobeT       strobe,
  output logic             inFrames,
  output logic [FW-1:0]    frameIdx,
  output phaseT            phase
);

  localparam logic [FW-1:0]    LAST_FRAME = FW'(NUM_IRQ - 1);
  localparam logic [CNT_W-1:0] START_LEN  = CNT_W'(START_MIN);
  localparam logic [CNT_W-1:0] QUIET_LEN  = CNT_W'(STOP_QUIET);
  localparam logic [CNT_W-1:0] CONT_LEN   = CNT_W'(STOP_CONT);

  stateT state;
  logic  startSeen;

  assign startSeen = lineIn && (lowCnt >= START_LEN);
  assign inFrames  = (state == ST_FRAMES);

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: begin
        if (startSeen)
          strobe.takeSnap = 1'b1;
        else if (quietMode && !reqSent && irqDiffers && lineIn)
          strobe.fireReq = 1'b1;
      end
      ST_STOPWAIT: begin
        if (lineIn && lowCnt == QUIET_LEN)     strobe.goQuiet = 1'b1;
        else if (lineIn && lowCnt >= CONT_LEN) strobe.goCont  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= PH_SAMPLE;
      frameIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobe.takeSnap) begin
            state    <= ST_FRAMES;
            phase    <= PH_SAMPLE;
            frameIdx <= '0;
          end
        end
        ST_FRAMES: begin
          case (phase)
            PH_SAMPLE:  phase <= PH_RECOVER;
            PH_RECOVER: phase <= PH_TURN;
            default: begin
              phase <= PH_SAMPLE;
              if (frameIdx == LAST_FRAME) state <= ST_STOPWAIT;
              else                        frameIdx <= frameIdx + 1'b1;
            end
          endcase
        end
        ST_STOPWAIT: begin
          if (strobe.goQuiet || strobe.goCont) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: sample is always followed by recovery inside the slots
  assert_phase_order_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FRAMES && phase == PH_SAMPLE) |=>
      (state == ST_FRAMES && phase == PH_RECOVER));

  // R4: slot index stays within the configured count
  assert_frame_bound_R4: assert property (@(posedge clk) disable iff (rst)
    inFrames |-> (frameIdx <= LAST_FRAME));

  // R8: the last turnaround leads to waiting for the stop pulse
  assert_stop_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FRAMES && frameIdx == LAST_FRAME && phase == PH_TURN) |=>
      (state == ST_STOPWAIT));

  // R2: a cycle only begins from idle
  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(inFrames) |-> ($past(state) == ST_IDLE));

endmodule

// File: rtl/sirqSlaveEncoder.sv
module sirqSlaveEncoder
  import sirqPkg::*;
#(
  parameter int NUM_IRQ    = 16,
  parameter int CNT_W      = 4,
  parameter int START_MIN  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               lineIn,
  output logic               lineOe,
  output logic               lineData
);

  localparam int FW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  ctrlStrobeT       strobe;
  logic             inFrames;
  logic [FW-1:0]    frameIdx;
  phaseT            phase;
  logic [CNT_W-1:0] lowCnt;
  logic             irqDiffers;
  logic             quietMode;
  logic             reqSent;

  sirqControl #(
    .NUM_IRQ(NUM_IRQ), .CNT_W(CNT_W), .START_MIN(START_MIN),
    .STOP_QUIET(STOP_QUIET), .STOP_CONT(STOP_CONT)
  ) i_ctrl (
    .clk(clk), .rst(rst), .lineIn(lineIn), .lowCnt(lowCnt),
    .irqDiffers(irqDiffers), .quietMode(quietMode), .reqSent(reqSent),
    .strobe(strobe), .inFrames(inFrames), .frameIdx(frameIdx), .phase(phase)
  );

  sirqDatapath #(
    .NUM_IRQ(NUM_IRQ), .CNT_W(CNT_W)
  ) i_data (
    .clk(clk), .rst(rst), .irqIn(irqIn), .lineIn(lineIn), .strobe(strobe),
    .inFrames(inFrames), .frameIdx(frameIdx), .phase(phase),
    .lowCnt(lowCnt), .irqDiffers(irqDiffers), .quietMode(quietMode),
    .reqSent(reqSent), .lineOe(lineOe), .lineData(lineData)
  );

endmodule

// File: tb/test_sirqSlaveEncoder.sv
module test_sirqSlaveEncoder;

  localparam int NI = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [NI-1:0] irqIn;
  logic          hostDrive;
  logic          lineWire;
  logic          lineOe;
  logic          lineData;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  // wired-AND of host pull-down and the block's pull-down
  assign lineWire = !(hostDrive || (lineOe && !lineData));

  sirqSlaveEncoder i_sirqSlaveEncoder (
    .clk(clk), .rst(rst), .irqIn(irqIn), .lineIn(lineWire),
    .lineOe(lineOe), .lineData(lineData)
  );

  task automatic chk(input string tag, input logic [1:0] exp);
    checks++;
    if ({lineOe, lineData} !== exp) begin
      errors++;
      $display("FAIL %s: oe,data got %b expected %b at %0t",
               tag, {lineOe, lineData}, exp, $time);
    end
  endtask

  task automatic hostLow(input int n);
    hostDrive = 1'b1;
    repeat (n) @(negedge clk);
    hostDrive = 1'b0;
  endtask

  task automatic checkFrames(input logic [NI-1:0] pat, input bit flip,
                             input string firstTag);
    for (int i = 0; i < 3 * NI; i++) begin
      int k;
      int p;
      string tag;
      k = i / 3;
      p = i % 3;
      @(negedge clk);
      if (i == 0)              tag = firstTag;
      else if (flip && i > 15) tag = "R7";
      else if (p == 2)         tag = "R4";
      else if (pat[k])         tag = "R5";
      else                     tag = "R6";
      chk(tag, {pat[k] && p != 2, pat[k] && p == 1});
      if (flip && i == 15) irqIn = ~pat;
    end
  endtask

  task automatic stopPulse(input int n);
    repeat (2) begin
      @(negedge clk);
      chk("R8", 2'b00);
    end
    hostLow(n);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    hostDrive = 1'b0;
    irqIn = '0;
    repeat (3) @(negedge clk);
    chk("R1", 2'b00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", 2'b00);
    // continuous mode after reset: no request on change
    irqIn = '1;
    repeat (4) begin
      @(negedge clk);
      chk("R1", 2'b00);
    end

    // sweep: every single-bit pattern plus mixed patterns
    for (int j = 0; j < 20; j++) begin
      logic [NI-1:0] pat;
      if (j < 16)       pat = NI'(1) << j;
      else if (j == 16) pat = 16'hA5C3;
      else if (j == 17) pat = 16'hFFFF;
      else if (j == 18) pat = 16'h0000;
      else              pat = 16'h3C96;
      irqIn = pat;
      hostLow(4 + j % 5);
      checkFrames(pat, (j % 3) == 0, "R2");
      stopPulse(3 + j % 2);
    end

    // R3: short low run must not start a cycle
    irqIn = '1;
    hostLow(3);
    repeat (6) begin
      @(negedge clk);
      chk("R3", 2'b00);
    end

    // select quiet mode with a 2-clock stop pulse
    irqIn = 16'h00F0;
    hostLow(4);
    checkFrames(16'h00F0, 1'b0, "R2");
    stopPulse(2);
    repeat (3) begin
      @(negedge clk);
      chk("R8", 2'b00);
    end

    // R9: change triggers a single-clock request
    irqIn = 16'h00F1;
    @(negedge clk);
    chk("R9", 2'b10);
    hostDrive = 1'b1;
    @(negedge clk);
    chk("R9", 2'b00);
    repeat (3) @(negedge clk);
    hostDrive = 1'b0;
    checkFrames(16'h00F1, 1'b0, "R11");

    // back to continuous, then a change must not request
    stopPulse(3);
    irqIn = 16'h0F00;
    repeat (5) begin
      @(negedge clk);
      chk("R10", 2'b00);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule